// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block produces the fetch address for a small 8-bit core whose program store holds 2K words of 13 bits. Each cycle it picks one request from its inputs: step to the next word, a near jump or call with a 10-bit target, a far jump or call with a full 11-bit target, a return, a hardware interrupt or a software trap. It then loads the program counter from that request. Near targets get their top address bit from a page register. The core sets that register with a separate page-select command.

Calls and interrupt entries save the next address on a five-entry return stack. A return restores the full address, whatever the page register holds. When the counter is redirected, the block spends one refill cycle in which the counter holds and every request is ignored, so redirections cost two cycles. Decoding, interrupt enables and the program store lie outside the block.

Top module: `pc_sequencer`

## Requirements
- R1: While rst_n is low the fetch address is 7FFh, the page bit is 0 and refill_o is 0. The return stack becomes empty with all entries zero.
- R2: step_i alone advances the fetch address by one, wrapping from 7FFh to 000h. With no request the address holds.
- R3: A near jump or near call loads address bits 9:0 from near_target_i and bit 10 from the page bit held before that cycle.
- R4: A far jump or far call loads all 11 bits from far_target_i, ignoring the page bit.
- R5: page_wr_i with page_data_i loads the page bit, which later near branches then use. Returns and interrupts leave the page bit unchanged.
- R6: A near call, far call, hardware interrupt or software trap pushes the current address plus one. A return loads the most recently pushed value that has not yet been popped.
- R7: The stack holds 5 entries in a ring. A sixth push overwrites the oldest entry without an error. The sixth pop after five pops wraps round to the newest entry.
- R8: A hardware interrupt loads 008h. A software trap loads 002h.
- R9: Priority, highest first: reset, hardware interrupt, software trap, return, far call, far jump, near call, near jump, step.
- R10: Every redirection (R3, R4, R6 return, R8) raises refill_o for the next cycle. In that cycle the address holds and all requests, including page writes and interrupts, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Advance to the next word |
| near_jump_i | input | 1 | Paged jump request |
| near_call_i | input | 1 | Paged call request |
| far_jump_i | input | 1 | Full-range jump request |
| far_call_i | input | 1 | Full-range call request |
| ret_i | input | 1 | Return request |
| hw_irq_i | input | 1 | Hardware interrupt entry |
| sw_irq_i | input | 1 | Software trap entry |
| near_target_i | input | 10 | Target for near branches |
| far_target_i | input | 11 | Target for far branches |
| page_wr_i | input | 1 | Page register write strobe |
| page_data_i | input | 1 | New page bit |
| fetch_addr_o | output | 11 | Current fetch address |
| page_o | output | 1 | Current page bit |
| refill_o | output | 1 | Refill cycle after a redirection |

## Verification
The bench uses the default parameters: an 11-bit counter, 10-bit near targets, one page bit and a stack depth of five. With these values the page bit visibly decides address bit 10 of near branches. The wrap from 7FFh to 000h occurs on the first step after reset. A chain of six far calls is enough to overflow the ring stack and make the pops wrap.

// File: rtl/pc_pkg.sv
package pc_pkg;

    typedef enum logic [3:0] {
        OP_HOLD,
        OP_STEP,
        OP_NJMP,
        OP_NCALL,
        OP_FJMP,
        OP_FCALL,
        OP_RET,
        OP_SWI,
        OP_HWI
    } pc_op_e;

endpackage

// File: rtl/pc_req_arbiter.sv
module pc_req_arbiter
    import pc_pkg::*;
(
    input  logic   refill_q_i,
    input  logic   step_i,
    input  logic   near_jump_i,
    input  logic   near_call_i,
    input  logic   far_jump_i,
    input  logic   far_call_i,
    input  logic   ret_i,
    input  logic   hw_irq_i,
    input  logic   sw_irq_i,
    output pc_op_e op_o
);

    // Fixed priority (R9); a refill cycle masks everything (R10).
    always_comb begin
        if (refill_q_i)       op_o = OP_HOLD;
        else if (hw_irq_i)    op_o = OP_HWI;
        else if (sw_irq_i)    op_o = OP_SWI;
        else if (ret_i)       op_o = OP_RET;
        else if (far_call_i)  op_o = OP_FCALL;
        else if (far_jump_i)  op_o = OP_FJMP;
        else if (near_call_i) op_o = OP_NCALL;
        else if (near_jump_i) op_o = OP_NJMP;
        else if (step_i)      op_o = OP_STEP;
        else                  op_o = OP_HOLD;
    end

endmodule

// File: rtl/pc_return_stack.sv
module pc_return_stack #(
    parameter int W     = 11,
    parameter int DEPTH = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] push_data_i,
    output logic [W-1:0] top_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] slot;
        logic [PTR_W-1:0]        ptr;
    } stk_t;

    stk_t stk_d, stk_q;
    logic [PTR_W-1:0] prev_idx, next_idx;

    assign prev_idx = (stk_q.ptr == '0) ? LAST_IDX : stk_q.ptr - 1'b1;
    assign next_idx = (stk_q.ptr == LAST_IDX) ? '0 : stk_q.ptr + 1'b1;
    assign top_o    = stk_q.slot[prev_idx];

    always_comb begin
        stk_d = stk_q;
        if (push_i) begin
            stk_d.slot[stk_q.ptr] = push_data_i;
            stk_d.ptr             = next_idx;
        end else if (pop_i) begin
            stk_d.ptr = prev_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    // R7: the ring pointer never leaves the entry range
    assert_ptr_in_ring_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stk_q.ptr <= LAST_IDX);

    // R6: a value just pushed is the one a return sees next
    assert_push_then_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> top_o == $past(push_data_i));

    // R6: push and pop never requested together by the sequencer
    assert_no_push_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pc_pkg::*;
#(
    parameter int PC_W   = 11,
    parameter int NEAR_W = 10,
    parameter int DEPTH  = 5,
    parameter logic [PC_W-1:0] HW_VEC = PC_W'('h008),
    parameter logic [PC_W-1:0] SW_VEC = PC_W'('h002)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              near_jump_i,
    input  logic              near_call_i,
    input  logic              far_jump_i,
    input  logic              far_call_i,
    input  logic              ret_i,
    input  logic              hw_irq_i,
    input  logic              sw_irq_i,
    input  logic [NEAR_W-1:0] near_target_i,
    input  logic [PC_W-1:0]   far_target_i,
    input  logic              page_wr_i,
    input  logic [PC_W-NEAR_W-1:0] page_data_i,
    output logic [PC_W-1:0]   fetch_addr_o,
    output logic [PC_W-NEAR_W-1:0] page_o,
    output logic              refill_o
);

    localparam int PAGE_W = PC_W - NEAR_W;
    localparam logic [PC_W-1:0] RESET_VEC = '1;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [PAGE_W-1:0] page;
        logic              refill;
    } seq_state_t;

    seq_state_t st_d, st_q;
    pc_op_e     op;
    logic       push, pop;
    logic [PC_W-1:0] pc_inc, stack_top;

    assign pc_inc = st_q.pc + 1'b1;

    pc_req_arbiter u_arb (
        .refill_q_i (st_q.refill),
        .step_i     (step_i),
        .near_jump_i(near_jump_i),
        .near_call_i(near_call_i),
        .far_jump_i (far_jump_i),
        .far_call_i (far_call_i),
        .ret_i      (ret_i),
        .hw_irq_i   (hw_irq_i),
        .sw_irq_i   (sw_irq_i),
        .op_o       (op)
    );

    pc_return_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .pop_i      (pop),
        .push_data_i(pc_inc),
        .top_o      (stack_top)
    );

    always_comb begin
        st_d        = st_q;
        st_d.refill = 1'b0;
        push        = 1'b0;
        pop         = 1'b0;
        unique case (op)
            OP_STEP:  st_d.pc = pc_inc;
            OP_NJMP:  st_d.pc = {st_q.page, near_target_i};
            OP_NCALL: begin st_d.pc = {st_q.page, near_target_i}; push = 1'b1; end
            OP_FJMP:  st_d.pc = far_target_i;
            OP_FCALL: begin st_d.pc = far_target_i; push = 1'b1; end
            OP_RET:   begin st_d.pc = stack_top;    pop  = 1'b1; end
            OP_SWI:   begin st_d.pc = SW_VEC;       push = 1'b1; end
            OP_HWI:   begin st_d.pc = HW_VEC;       push = 1'b1; end
            default:  ;
        endcase
        if (op != OP_HOLD && op != OP_STEP) st_d.refill = 1'b1;
        if (!st_q.refill && page_wr_i)      st_d.page   = page_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pc: RESET_VEC, page: '0, refill: 1'b0};
        else        st_q <= st_d;
    end

    assign fetch_addr_o = st_q.pc;
    assign page_o       = st_q.page;
    assign refill_o     = st_q.refill;

    // R10: refill lasts one cycle and freezes the address
    assert_refill_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        refill_o |=> (!refill_o && $stable(fetch_addr_o)));

    // R8: hardware interrupt outside refill lands on its vector
    assert_hw_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!refill_o && hw_irq_i) |=> (fetch_addr_o == HW_VEC && refill_o));

    // R9: a trap without hardware interrupt lands on the trap vector
    assert_sw_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!refill_o && sw_irq_i && !hw_irq_i) |=> fetch_addr_o == SW_VEC);

    // R3: near branch combines old page with the short target
    assert_near_paged_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NJMP || op == OP_NCALL) |=>
            fetch_addr_o == {$past(page_o), $past(near_target_i)});

    // R2: plain step advances by one
    assert_step_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP) |=> fetch_addr_o == $past(fetch_addr_o) + 1'b1);

    // R5: page bit untouched by interrupts and returns without a write
    assert_page_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_RET || op == OP_HWI || op == OP_SWI) && !page_wr_i) |=> $stable(page_o));

endmodule

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 0, near_jump_i = 0, near_call_i = 0, far_jump_i = 0;
    logic        far_call_i = 0, ret_i = 0, hw_irq_i = 0, sw_irq_i = 0;
    logic [9:0]  near_target_i = '0;
    logic [10:0] far_target_i = '0;
    logic        page_wr_i = 0;
    logic [0:0]  page_data_i = '0;
    logic [10:0] fetch_addr_o;
    logic [0:0]  page_o;
    logic        refill_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pc_sequencer u_pc_sequencer (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .near_jump_i(near_jump_i),
        .near_call_i(near_call_i), .far_jump_i(far_jump_i), .far_call_i(far_call_i),
        .ret_i(ret_i), .hw_irq_i(hw_irq_i), .sw_irq_i(sw_irq_i),
        .near_target_i(near_target_i), .far_target_i(far_target_i),
        .page_wr_i(page_wr_i), .page_data_i(page_data_i),
        .fetch_addr_o(fetch_addr_o), .page_o(page_o), .refill_o(refill_o)
    );

    // cmd bits: {hw, sw, ret, fcall, fjmp, ncall, njmp, step, pgwr}
    // fields: cmd9, pgdata1, near10, far11, exp_pc11, exp_page1, exp_refill1
    localparam int NV = 42;
    localparam logic [43:0] VEC [NV] = '{
        {9'b000000010, 1'b0, 10'h000, 11'h000, 11'h000, 1'b0, 1'b0}, // R2 wrap
        {9'b000000010, 1'b0, 10'h000, 11'h000, 11'h001, 1'b0, 1'b0},
        {9'b000000011, 1'b1, 10'h000, 11'h000, 11'h002, 1'b1, 1'b0}, // R5
        {9'b000000110, 1'b0, 10'h155, 11'h000, 11'h555, 1'b1, 1'b1}, // R3 R9
        {9'b000000010, 1'b0, 10'h000, 11'h000, 11'h555, 1'b1, 1'b0}, // R10
        {9'b000001001, 1'b0, 10'h020, 11'h000, 11'h420, 1'b0, 1'b1}, // R3 old page
        {9'b000000011, 1'b1, 10'h000, 11'h000, 11'h420, 1'b0, 1'b0}, // R10 ignored
        {9'b000000011, 1'b1, 10'h000, 11'h000, 11'h421, 1'b1, 1'b0},
        {9'b000001000, 1'b0, 10'h030, 11'h000, 11'h430, 1'b1, 1'b1},
        {9'b000000000, 1'b0, 10'h000, 11'h000, 11'h430, 1'b1, 1'b0},
        {9'b001000000, 1'b0, 10'h000, 11'h000, 11'h422, 1'b1, 1'b1}, // R6
        {9'b000000000, 1'b0, 10'h000, 11'h000, 11'h422, 1'b1, 1'b0},
        {9'b001000000, 1'b0, 10'h000, 11'h000, 11'h556, 1'b1, 1'b1}, // R6
        {9'b000000000, 1'b0, 10'h000, 11'h000, 11'h556, 1'b1, 1'b0},
        {9'b000010000, 1'b0, 10'h000, 11'h7A0, 11'h7A0, 1'b1, 1'b1}, // R4
        {9'b000000000, 1'b0, 10'h000, 11'h000, 11'h7A0, 1'b1, 1'b0},
        {9'b000100000, 1'b0, 10'h000, 11'h123, 11'h123, 1'b1, 1'b1}, // R4
        {9'b000000000, 1'b0, 10'h000, 11'h000, 11'h123, 1'b1, 1'b0},
        {9'b100100010, 1'b0, 10'h000, 11'h600, 11'h008, 1'b1, 1'b1}, // R8 R9
        {9'b100000010, 1'b0, 10'h000, 11'h000, 11'h008, 1'b1, 1'b0}, // R10
        {9'b011000000, 1'b0, 10'h000, 11'h000, 11'h002, 1'b1, 1'b1}, // R8 R9
        {9'b000000000, 1'b0, 10'h000, 11'h000, 11'h002, 1'b1, 1'b0},
        {9'b001000000, 1'b0, 10'h000, 11'h000, 11'h009, 1'b1, 1'b1},
        {9'b000000000, 1'b0, 10'h000, 11'h000, 11'h009, 1'b1, 1'b0},
        {9'b001000000, 1'b0, 10'h000, 11'h000, 11'h124, 1'b1, 1'b1},
        {9'b000000000, 1'b0, 10'h000, 11'h000, 11'h124, 1'b1, 1'b0},
        {9'b001000000, 1'b0, 10'h000, 11'h000, 11'h7A1, 1'b1, 1'b1},
        {9'b000000000, 1'b0, 10'h000, 11'h000, 11'h7A1, 1'b1, 1'b0},
        {9'b000000000, 1'b0, 10'h000, 11'h000, 11'h7A1, 1'b1, 1'b0}, // R2 hold
        {9'b000000010, 1'b0, 10'h000, 11'h000, 11'h7A2, 1'b1, 1'b0},
        {9'b000010100, 1'b0, 10'h3FF, 11'h055, 11'h055, 1'b1, 1'b1}, // R9
        {9'b000000000, 1'b0, 10'h000, 11'h000, 11'h055, 1'b1, 1'b0},
        {9'b000000100, 1'b0, 10'h011, 11'h000, 11'h411, 1'b1, 1'b1}, // R5 kept
        {9'b000000000, 1'b0, 10'h000, 11'h000, 11'h411, 1'b1, 1'b0},
        {9'b000101000, 1'b0, 10'h001, 11'h700, 11'h700, 1'b1, 1'b1}, // R9
        {9'b000000000, 1'b0, 10'h000, 11'h000, 11'h700, 1'b1, 1'b0},
        {9'b001100000, 1'b0, 10'h000, 11'h100, 11'h412, 1'b1, 1'b1}, // R9
        {9'b000000000, 1'b0, 10'h000, 11'h000, 11'h412, 1'b1, 1'b0},
        {9'b010000010, 1'b0, 10'h000, 11'h000, 11'h002, 1'b1, 1'b1}, // R8
        {9'b000000000, 1'b0, 10'h000, 11'h000, 11'h002, 1'b1, 1'b0},
        {9'b001000000, 1'b0, 10'h000, 11'h000, 11'h413, 1'b1, 1'b1}, // R6
        {9'b000000000, 1'b0, 10'h000, 11'h000, 11'h413, 1'b1, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [8:0] cmd, input logic pd,
                         input logic [9:0] nt, input logic [10:0] ft);
        {hw_irq_i, sw_irq_i, ret_i, far_call_i, far_jump_i,
         near_call_i, near_jump_i, step_i, page_wr_i} = cmd;
        page_data_i   = pd;
        near_target_i = nt;
        far_target_i  = ft;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        apply(9'b0, 1'b0, 10'h0, 11'h0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 reset pc", 32'(fetch_addr_o), 32'h7FF);
        check("R1 reset page", 32'(page_o), 32'h0);
        check("R1 reset refill", 32'(refill_o), 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][43:35], VEC[i][34], VEC[i][33:24], VEC[i][23:13]);
            check($sformatf("R2-vector %0d pc", i), 32'(fetch_addr_o), 32'(VEC[i][12:2]));
            check($sformatf("R5 vector %0d page", i), 32'(page_o), 32'(VEC[i][1]));
            check($sformatf("R10 vector %0d refill", i), 32'(refill_o), 32'(VEC[i][0]));
        end

        // R1: reset mid-run with requests active
        near_jump_i = 1'b1; page_wr_i = 1'b1; page_data_i = 1'b1;
        rst_n = 1'b0;
        #1;
        check("R1 async reset pc", 32'(fetch_addr_o), 32'h7FF);
        check("R1 async reset page", 32'(page_o), 32'h0);
        do_reset();
        apply(9'b000000100, 1'b0, 10'h011, 11'h0);
        check("R3 near after reset page0", 32'(fetch_addr_o), 32'h011);
        apply(9'b0, 1'b0, 10'h0, 11'h0);

        // R7: six calls overflow the five-entry ring
        do_reset();
        for (int k = 1; k <= 6; k++) begin
            apply(9'b000100000, 1'b0, 10'h0, 11'(k * 'h100));
            check("R4 far call target", 32'(fetch_addr_o), 32'(k * 'h100));
            apply(9'b0, 1'b0, 10'h0, 11'h0);
        end
        begin
            logic [10:0] exp_pop [6] = '{11'h501, 11'h401, 11'h301, 11'h201, 11'h101, 11'h501};
            for (int k = 0; k < 6; k++) begin
                apply(9'b001000000, 1'b0, 10'h0, 11'h0);
                check($sformatf("R7 ring pop %0d", k), 32'(fetch_addr_o), 32'(exp_pop[k]));
                apply(9'b0, 1'b0, 10'h0, 11'h0);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule